// File: doc/BRIEF.md
# Reset Cause Controller

This block merges every reset request in the chip into one stretched system reset and records which request started the most recent reset. The requests come from the power-on input, a supply-low detector, an external pin, a watchdog overflow, a missing-clock detector, an active-low comparator output, a flash access error and a software write. The detection circuits themselves are outside the block. They reach it only as request lines that are already synchronous to `clk`.

Software sees one 8-bit register at byte address 0xEF on a simple bus with address, write strobe, write data and combinational read data. The register is asymmetric. A read of a bit returns a sticky cause flag, and a write to the same bit sets a source enable or forces a reset. The flags and the enables survive every reset except power-on, so code that runs after a reset can find out why it happened. A read-modify-write sequence on this register copies the flags into the enables, so software should write the enable values directly.

Top module: `reset_cause_unit`

## Requirements
- R1: The register decodes only at address 0xEF. A read there returns 0 in bit 7 and the cause flags in bits 6..0, and a read at any other address returns 0x00. Writing bit 7 has no effect.
- R2: While `pwrOnReq` is high, `sysRstOut` is high, all enables are cleared and the flags read 0x02. After `pwrOnReq` falls, `sysRstOut` stays high for 16 rising edges and goes low after the 16th.
- R3: When several requests are seen on the same edge, the captured flag is the one with the highest priority. The order from highest to lowest is supply/power-on (bit 1), pin (bit 0), watchdog (bit 3), missing clock (bit 2), comparator (bit 5), flash error (bit 6), software (bit 4).
- R4: Flags are captured only on the edge that starts a reset while `sysRstOut` is low, and exactly one flag is then set. Requests that arrive while the reset is already asserted do not change the flags.
- R5: `sysRstOut` rises after the first edge that samples an active request. After the last edge that samples a request, it stays high for 15 more edges and falls on the 16th.
- R6: Writing 1 to bit 4 starts a reset on the edge after the write edge. The flags then read 0x10.
- R7: A watchdog overflow is registered and starts a reset one edge later, with the flags reading 0x08. A pin request reads back as 0x01 and a flash error as 0x40. These three sources are always enabled.
- R8: The comparator request is active low (`cmpOutN` = 0) and is honoured only when the comparator enable, written through bit 5, is 1. The flag then reads 0x20. When the enable is 0 the request causes no reset.
- R9: The missing-clock request is honoured only when the enable written through bit 2 is 1. The flag then reads 0x04. When the enable is 0 the request causes no reset.
- R10: The supply-low request is honoured only when the enable written through bit 1 is 1. The flag then reads 0x02. Enables keep their values across any reset other than power-on.
- R11: Register writes made while `sysRstOut` is high are ignored, including the software force bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwrOnReq | input | 1 | Power-on request. Active high and asynchronous, it clears all stored state |
| supplyLowReq | input | 1 | Supply-low detector request, active high |
| pinReq | input | 1 | External pin reset request, active high, already synchronised |
| wdtOvf | input | 1 | Watchdog overflow pulse |
| mcdTimeout | input | 1 | Missing-clock detector timeout |
| cmpOutN | input | 1 | Comparator output. A low level requests a reset |
| flashErr | input | 1 | Flash access error request |
| busAddr | input | 8 | Register bus byte address |
| busWrEn | input | 1 | Register bus write strobe |
| busWrData | input | 8 | Register bus write data |
| busRdData | output | 8 | Register bus read data (combinational) |
| sysRstOut | output | 1 | Stretched system reset, active high |

## Verification
The assertions check the following on every cycle:
- After power-on, exactly one flag is set.
- The flags and the enables hold their values unless their own strobe is active.
- A sampled request is always followed by an asserted reset.
- The reset never falls directly after a cycle that had a request.
- A software force or a watchdog overflow leads to reset two edges later.

Some behaviours can only be shown by the bench's scenarios: which flag wins when requests coincide, the exact 16-edge release, that disabled sources and writes during reset leave no trace, and that enables survive a pin reset but not a power-on.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  localparam int NUM_CAUSE   = 7;
  localparam int CAUSE_IDX_W = $clog2(NUM_CAUSE);

  typedef logic [CAUSE_IDX_W-1:0] cause_idx_t;

  // Register bit positions (software decodes these)
  localparam cause_idx_t BIT_PIN   = 3'd0;
  localparam cause_idx_t BIT_VMON  = 3'd1;
  localparam cause_idx_t BIT_MCD   = 3'd2;
  localparam cause_idx_t BIT_WDT   = 3'd3;
  localparam cause_idx_t BIT_SW    = 3'd4;
  localparam cause_idx_t BIT_CMP   = 3'd5;
  localparam cause_idx_t BIT_FLASH = 3'd6;

  // Priority rank (0 = highest) to register bit position
  function automatic cause_idx_t rankToBit(input int unsigned rank);
    case (rank)
      0:       return BIT_VMON;
      1:       return BIT_PIN;
      2:       return BIT_WDT;
      3:       return BIT_MCD;
      4:       return BIT_CMP;
      5:       return BIT_FLASH;
      default: return BIT_SW;
    endcase
  endfunction

  // Control to datapath strobes
  typedef struct packed {
    logic                 captureStb;
    logic [NUM_CAUSE-1:0] causeOneHot;
    logic                 cfgWriteStb;
    logic                 cfgCmp;
    logic                 cfgMcd;
    logic                 cfgVmon;
  } rcu_strobe_t;

  // Source enables held in the datapath
  typedef struct packed {
    logic cmp;
    logic mcd;
    logic vmon;
  } rcu_enable_t;

endpackage

// File: rtl/rcu_ctrl.sv
module rcu_ctrl
  import rcu_pkg::*;
#(
  parameter int                ADDR_W         = 8,
  parameter int                DATA_W         = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR       = 8'hEF,
  parameter int                STRETCH_CYCLES = 16
) (
  input  logic              clk,
  input  logic              pwrOnReq,
  input  logic              supplyLowReq,
  input  logic              pinReq,
  input  logic              wdtOvf,
  input  logic              mcdTimeout,
  input  logic              cmpOutN,
  input  logic              flashErr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  rcu_enable_t       enables,
  output rcu_strobe_t       strobes,
  output logic              sysRstOut
);

  localparam int              CNT_W    = $clog2(STRETCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYCLES);

  logic [CNT_W-1:0]     stretchCnt;
  logic                 swPend;
  logic                 wdtSeen;
  logic                 wrAccepted;
  logic [NUM_CAUSE-1:0] reqPrio;
  logic [NUM_CAUSE-1:0] grant;
  logic [NUM_CAUSE-1:0] causeOneHot;
  logic                 anyReq;
  logic                 unusedWrBits;

  assign unusedWrBits = ^{busWrData[DATA_W-1:BIT_FLASH], busWrData[BIT_WDT], busWrData[BIT_PIN]};

  // Register writes are accepted only outside reset
  assign wrAccepted = busWrEn && (busAddr == REG_ADDR) && !sysRstOut;

  // Registered sources: software force and watchdog overflow
  always_ff @(posedge clk or posedge pwrOnReq) begin
    if (pwrOnReq) begin
      swPend  <= 1'b0;
      wdtSeen <= 1'b0;
    end else begin
      swPend  <= wrAccepted && busWrData[BIT_SW];
      wdtSeen <= wdtOvf;
    end
  end

  // Requests in priority order, rank 0 highest
  always_comb begin
    reqPrio    = '0;
    reqPrio[0] = supplyLowReq && enables.vmon;
    reqPrio[1] = pinReq;
    reqPrio[2] = wdtSeen;
    reqPrio[3] = mcdTimeout && enables.mcd;
    reqPrio[4] = !cmpOutN && enables.cmp;
    reqPrio[5] = flashErr;
    reqPrio[6] = swPend;
  end

  assign anyReq = |reqPrio;

  // Fixed-priority grant
  for (genvar gi = 0; gi < NUM_CAUSE; gi++) begin : gGrant
    if (gi == 0) begin : gTop
      assign grant[gi] = reqPrio[gi];
    end else begin : gRest
      assign grant[gi] = reqPrio[gi] && !(|reqPrio[gi-1:0]);
    end
  end

  // Map rank to register bit
  always_comb begin
    causeOneHot = '0;
    for (int k = 0; k < NUM_CAUSE; k++) begin
      causeOneHot[rankToBit(k)] = grant[k];
    end
  end

  // Reset stretch counter
  always_ff @(posedge clk or posedge pwrOnReq) begin
    if (pwrOnReq) begin
      stretchCnt <= CNT_LOAD;
    end else if (anyReq) begin
      stretchCnt <= CNT_LOAD;
    end else if (stretchCnt != '0) begin
      stretchCnt <= stretchCnt - CNT_W'(1);
    end
  end

  assign sysRstOut = (stretchCnt != '0);

  always_comb begin
    strobes             = '0;
    strobes.captureStb  = anyReq && (stretchCnt == '0);
    strobes.causeOneHot = causeOneHot;
    strobes.cfgWriteStb = wrAccepted;
    strobes.cfgCmp      = busWrData[BIT_CMP];
    strobes.cfgMcd      = busWrData[BIT_MCD];
    strobes.cfgVmon     = busWrData[BIT_VMON];
  end

  // R5: a sampled request always yields an asserted reset
  assert_rst_follows_req_R5: assert property (@(posedge clk) disable iff (pwrOnReq)
    anyReq |=> sysRstOut);

  // R5: reset never releases right after a cycle with a request
  assert_rst_release_quiet_R5: assert property (@(posedge clk) disable iff (pwrOnReq)
    $fell(sysRstOut) |-> !$past(anyReq));

  // R5: an idle block with no request stays out of reset
  assert_no_spurious_rst_R5: assert property (@(posedge clk) disable iff (pwrOnReq)
    (!anyReq && !sysRstOut) |=> !sysRstOut);

  // R6: a software force reaches the reset output two edges later
  assert_sw_force_R6: assert property (@(posedge clk) disable iff (pwrOnReq)
    (wrAccepted && busWrData[BIT_SW]) |-> ##2 sysRstOut);

  // R7: a watchdog overflow reaches the reset output two edges later
  assert_wdt_delay_R7: assert property (@(posedge clk) disable iff (pwrOnReq)
    wdtOvf |-> ##2 sysRstOut);

  // R4: capture only starts a reset from the idle state
  assert_capture_idle_R4: assert property (@(posedge clk) disable iff (pwrOnReq)
    strobes.captureStb |-> ($onehot(strobes.causeOneHot) && !sysRstOut));

endmodule

// File: rtl/rcu_regs.sv
module rcu_regs
  import rcu_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF
) (
  input  logic              clk,
  input  logic              pwrOnReq,
  input  rcu_strobe_t       strobes,
  input  logic [ADDR_W-1:0] busAddr,
  output rcu_enable_t       enables,
  output logic [DATA_W-1:0] busRdData
);

  localparam int FLAG_W = DATA_W - 1;

  logic [FLAG_W-1:0] causeFlags;

  // Sticky cause flags: only power-on clears them
  always_ff @(posedge clk or posedge pwrOnReq) begin
    if (pwrOnReq) begin
      causeFlags <= FLAG_W'(1) << BIT_VMON;
    end else if (strobes.captureStb) begin
      causeFlags <= FLAG_W'(strobes.causeOneHot);
    end
  end

  // Source enables: only power-on clears them
  always_ff @(posedge clk or posedge pwrOnReq) begin
    if (pwrOnReq) begin
      enables <= '0;
    end else if (strobes.cfgWriteStb) begin
      enables.cmp  <= strobes.cfgCmp;
      enables.mcd  <= strobes.cfgMcd;
      enables.vmon <= strobes.cfgVmon;
    end
  end

  // Read: top bit always zero
  assign busRdData = (busAddr == REG_ADDR) ? DATA_W'(causeFlags) : '0;

  // R4: exactly one cause flag is set at all times after power-on
  assert_single_flag_R4: assert property (@(posedge clk) disable iff (pwrOnReq)
    $countones(causeFlags) == 1);

  // R4: flags hold unless a reset event captures a new cause
  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (pwrOnReq)
    !strobes.captureStb |=> $stable(causeFlags));

  // R10 / R11: enables hold unless an accepted write updates them
  assert_enables_hold_R10: assert property (@(posedge clk) disable iff (pwrOnReq)
    !strobes.cfgWriteStb |=> $stable(enables));

endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
  import rcu_pkg::*;
#(
  parameter int                ADDR_W         = 8,
  parameter int                DATA_W         = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR       = 8'hEF,
  parameter int                STRETCH_CYCLES = 16
) (
  input  logic              clk,
  input  logic              pwrOnReq,
  input  logic              supplyLowReq,
  input  logic              pinReq,
  input  logic              wdtOvf,
  input  logic              mcdTimeout,
  input  logic              cmpOutN,
  input  logic              flashErr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              sysRstOut
);

  rcu_strobe_t strobes;
  rcu_enable_t enables;

  rcu_ctrl #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .REG_ADDR      (REG_ADDR),
    .STRETCH_CYCLES(STRETCH_CYCLES)
  ) ctrl_i (
    .clk         (clk),
    .pwrOnReq    (pwrOnReq),
    .supplyLowReq(supplyLowReq),
    .pinReq      (pinReq),
    .wdtOvf      (wdtOvf),
    .mcdTimeout  (mcdTimeout),
    .cmpOutN     (cmpOutN),
    .flashErr    (flashErr),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .enables     (enables),
    .strobes     (strobes),
    .sysRstOut   (sysRstOut)
  );

  rcu_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(REG_ADDR)
  ) regs_i (
    .clk      (clk),
    .pwrOnReq (pwrOnReq),
    .strobes  (strobes),
    .busAddr  (busAddr),
    .enables  (enables),
    .busRdData(busRdData)
  );

endmodule

// File: tb/reset_cause_unit_tb_top.sv
module reset_cause_unit_tb_top;

  localparam logic [7:0] REG_A   = 8'hEF;
  localparam int         STRETCH = 16;

  typedef struct packed {
    logic [7:0] en;       // enable byte written first
    logic [6:0] req;      // {flash, cmp, sw, wdt, mcd, vmon, pin}
    logic [7:0] expFlags;
    logic       expRst;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 7'h01, 8'h01, 1'b1},  // R7 pin
    '{8'h00, 7'h08, 8'h08, 1'b1},  // R7 watchdog
    '{8'h00, 7'h40, 8'h40, 1'b1},  // R7 flash
    '{8'h00, 7'h10, 8'h10, 1'b1},  // R6 software
    '{8'h00, 7'h20, 8'h10, 1'b0},  // R8 comparator disabled
    '{8'h20, 7'h20, 8'h20, 1'b1},  // R8 comparator enabled
    '{8'h00, 7'h04, 8'h20, 1'b0},  // R9 mcd disabled
    '{8'h04, 7'h04, 8'h04, 1'b1},  // R9 mcd enabled
    '{8'h00, 7'h02, 8'h04, 1'b0},  // R10 supply disabled
    '{8'h02, 7'h02, 8'h02, 1'b1},  // R10 supply enabled
    '{8'h26, 7'h64, 8'h04, 1'b1},  // R3 mcd over cmp, flash
    '{8'h26, 7'h60, 8'h20, 1'b1},  // R3 cmp over flash
    '{8'h26, 7'h50, 8'h40, 1'b1},  // R3 flash over sw
    '{8'h26, 7'h07, 8'h02, 1'b1},  // R3 supply over pin, mcd
    '{8'h26, 7'h05, 8'h01, 1'b1},  // R3 pin over mcd
    '{8'h00, 7'h18, 8'h08, 1'b1}   // R3 watchdog over sw
  };

  logic       clk = 1'b0;
  logic       pwrOnReq = 1'b1;
  logic       supplyLowReq = 1'b0;
  logic       pinReq = 1'b0;
  logic       wdtOvf = 1'b0;
  logic       mcdTimeout = 1'b0;
  logic       cmpOutN = 1'b1;
  logic       flashErr = 1'b0;
  logic [7:0] busAddr = REG_A;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       sysRstOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  reset_cause_unit dut_i (
    .clk         (clk),
    .pwrOnReq    (pwrOnReq),
    .supplyLowReq(supplyLowReq),
    .pinReq      (pinReq),
    .wdtOvf      (wdtOvf),
    .mcdTimeout  (mcdTimeout),
    .cmpOutN     (cmpOutN),
    .flashErr    (flashErr),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .sysRstOut   (sysRstOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [7:0] addr, output logic [7:0] val);
    busAddr = addr;
    #1;
    val = busRdData;
    busAddr = REG_A;
  endtask

  task automatic writeAt(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = REG_A;
  endtask

  task automatic waitIdle();
    while (sysRstOut) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulseCmp();
    @(negedge clk); cmpOutN = 1'b0;
    @(negedge clk); cmpOutN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;

    // R2: power-on state and release timing
    repeat (3) @(negedge clk);
    check("R2 rst during power-on", 8'(sysRstOut), 8'h01);
    pwrOnReq = 1'b0;
    repeat (STRETCH - 1) @(negedge clk);
    check("R2 rst held 15 edges", 8'(sysRstOut), 8'h01);
    @(negedge clk);
    check("R2 rst low after 16 edges", 8'(sysRstOut), 8'h00);
    readAt(REG_A, rd);
    check("R2 flags after power-on", rd, 8'h02);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      waitIdle();
      writeAt(REG_A, VECS[v].en);
      @(negedge clk);
      pinReq       = VECS[v].req[0];
      supplyLowReq = VECS[v].req[1];
      mcdTimeout   = VECS[v].req[2];
      wdtOvf       = VECS[v].req[3];
      busWrEn      = VECS[v].req[4];
      busWrData    = VECS[v].en | 8'h10;
      cmpOutN      = !VECS[v].req[5];
      flashErr     = VECS[v].req[6];
      @(negedge clk);
      pinReq = 1'b0; supplyLowReq = 1'b0; mcdTimeout = 1'b0; wdtOvf = 1'b0;
      busWrEn = 1'b0; cmpOutN = 1'b1; flashErr = 1'b0;
      @(negedge clk);
      check($sformatf("R3-R10 vector %0d reset", v), 8'(sysRstOut), 8'(VECS[v].expRst));
      repeat (STRETCH + 4) @(negedge clk);
      check($sformatf("R5 vector %0d released", v), 8'(sysRstOut), 8'h00);
      readAt(REG_A, rd);
      check($sformatf("R3-R10 vector %0d flags", v), rd, VECS[v].expFlags);
    end

    // R5 / R4: held pin, then flash during reset, exact release
    waitIdle();
    writeAt(REG_A, 8'h00);
    @(negedge clk); pinReq = 1'b1;
    repeat (4) @(negedge clk);
    pinReq = 1'b0; flashErr = 1'b1;
    @(negedge clk); flashErr = 1'b0;
    repeat (STRETCH - 1) @(negedge clk);
    check("R5 held 15 edges after last request", 8'(sysRstOut), 8'h01);
    @(negedge clk);
    check("R5 released on 16th edge", 8'(sysRstOut), 8'h00);
    readAt(REG_A, rd);
    check("R4 flag unchanged by request during reset", rd, 8'h01);

    // R11: writes during reset are ignored
    @(negedge clk); pinReq = 1'b1;
    @(negedge clk); pinReq = 1'b0;
    writeAt(REG_A, 8'h30);
    waitIdle();
    check("R11 software force during reset ignored", 8'(sysRstOut), 8'h00);
    pulseCmp();
    check("R11 enable write during reset ignored", 8'(sysRstOut), 8'h00);
    readAt(REG_A, rd);
    check("R11 flags after ignored writes", rd, 8'h01);

    // R1: other address and bit 7
    writeAt(8'hEE, 8'h10);
    @(negedge clk);
    check("R1 write to other address no reset", 8'(sysRstOut), 8'h00);
    readAt(8'hEE, rd);
    check("R1 other address reads zero", rd, 8'h00);
    writeAt(REG_A, 8'h80);
    @(negedge clk);
    check("R1 bit 7 write no reset", 8'(sysRstOut), 8'h00);
    readAt(REG_A, rd);
    check("R1 bit 7 reads zero", rd, 8'h01);

    // R10: enables survive pin reset
    writeAt(REG_A, 8'h20);
    @(negedge clk); pinReq = 1'b1;
    @(negedge clk); pinReq = 1'b0;
    waitIdle();
    pulseCmp();
    check("R10 enable kept across pin reset", 8'(sysRstOut), 8'h01);
    waitIdle();
    readAt(REG_A, rd);
    check("R8 comparator flag", rd, 8'h20);

    // R2: power-on clears enables
    @(negedge clk); pwrOnReq = 1'b1;
    @(negedge clk); pwrOnReq = 1'b0;
    waitIdle();
    pulseCmp();
    check("R2 enables cleared by power-on", 8'(sysRstOut), 8'h00);
    readAt(REG_A, rd);
    check("R2 flags after second power-on", rd, 8'h02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule